// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps six segment base registers and turns a segment-relative byte offset into a physical byte address. A requester presents an access kind together with the candidate offsets (instruction pointer, instruction address field, stack pointer and destination index). The kind picks both the offset and the segment base implicitly. The block adds the zero-extended base and offset and returns the 20-bit sum one cycle later on a registered output.

A data access may name any other segment through an override select that carries its own valid bit. The other access kinds ignore the override. Software loads the segment bases through a plain write port. A write alters the base only from the following clock edge onward.

Requests enter on a valid/ready handshake and addresses leave on another. The output stage is a single register. It accepts a new request whenever it is empty or its current address is consumed in the same cycle. While the consumer holds `out_ready` low with an address pending, `req_ready` drops and the pending address is frozen. No request is lost or duplicated under back-pressure.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset `out_valid` is 0 and all six segment bases are zero, so a fetch with instruction pointer P yields address P.
- R2: With `wr_en` high and `wr_sel` in 0..5, the base at that index takes `wr_base` at the clock edge. A request accepted in the same cycle as the write still uses the old base. `wr_sel` values 6 and 7 change no base. Segment index encoding: 0 code, 1 data, 2 stack, 3 extra, 4 second extra, 5 third extra.
- R3: Access kind 0 (instruction fetch) yields code base + `req_ip`. The override inputs are ignored.
- R4: Access kind 1 (data) without a valid override yields data base + `req_field`. For example, base 038E0h with offset 0032h gives 03912h.
- R5: For access kind 1 with `req_ovr_valid` high, an `req_ovr_sel` in 0..5 replaces the data segment with that segment index. The values 6 and 7 fall back to the data segment.
- R6: Access kind 2 (stack) yields stack base + `req_sp`. The override inputs are ignored.
- R7: Access kind 3 (string destination) yields extra base + `req_di`. The override inputs are ignored.
- R8: The base and the offset are zero-extended to 20 bits before the add, and the carry out of bit 19 is dropped (FFFF0h + FFFFh = 0FFEFh).
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` both high) makes `out_valid` high with its address after that edge. Without a new acceptance, a consumed output clears `out_valid`.
- R10: While `out_valid` is high and `out_ready` is low, `req_ready` is low and `out_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment base write enable |
| wr_sel | input | 3 | Segment index to write |
| wr_base | input | 20 | New segment base value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | Access kind: 0 fetch, 1 data, 2 stack, 3 string destination |
| req_ovr_valid | input | 1 | Segment override present (data kind only) |
| req_ovr_sel | input | 3 | Override segment index |
| req_ip | input | 16 | Instruction pointer offset |
| req_field | input | 16 | Instruction address field offset |
| req_sp | input | 16 | Stack pointer offset |
| req_di | input | 16 | Destination index offset |
| out_valid | output | 1 | Physical address present |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | 20 | Physical byte address |

## Verification
Each access kind is issued against six distinct bases with distinct values on all four offset inputs. A wrong segment or a wrong offset therefore produces a different address. The override is swept across all eight select codes on data requests and then applied to fetch, stack and string-destination requests. This separates the honoured, fallback and ignored cases. Writes coinciding with requests distinguish the old base from the new one, and a near-top base with a large offset exposes a missing truncation. Random request, write and `out_ready` streams check under stalls that no address is dropped, repeated or altered.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_DATA   = 2'd1,
    KIND_STACK  = 2'd2,
    KIND_STRDST = 2'd3
  } acc_kind_e;

  localparam int SEG_COUNT  = 6;
  localparam int SEG_SEL_W  = 3;

  localparam logic [SEG_SEL_W-1:0] SEG_CODE  = 3'd0;
  localparam logic [SEG_SEL_W-1:0] SEG_DATA  = 3'd1;
  localparam logic [SEG_SEL_W-1:0] SEG_STACK = 3'd2;
  localparam logic [SEG_SEL_W-1:0] SEG_EXTRA = 3'd3;

endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int NUM   = 6,
  parameter int SEL_W = 3,
  parameter int W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [W-1:0]     rd_base
);

  logic [W-1:0] bases [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        q <= wr_data;
      end
    end
    assign bases[g] = q;
  end

  always_comb begin
    rd_base = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_sel == SEL_W'(i)) rd_base = bases[i];
    end
  end

endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  acc_kind_e            kind,
  input  logic                 ovr_valid,
  input  logic [SEG_SEL_W-1:0] ovr_sel,
  input  logic [OFS_W-1:0]     ip,
  input  logic [OFS_W-1:0]     field,
  input  logic [OFS_W-1:0]     sp,
  input  logic [OFS_W-1:0]     di,
  output logic [SEG_SEL_W-1:0] seg_idx,
  output logic [OFS_W-1:0]     ofs
);

  logic ovr_legal;
  assign ovr_legal = ovr_valid && (int'(ovr_sel) < SEG_COUNT);

  always_comb begin
    unique case (kind)
      KIND_FETCH: begin
        seg_idx = SEG_CODE;
        ofs     = ip;
      end
      KIND_DATA: begin
        seg_idx = ovr_legal ? ovr_sel : SEG_DATA;
        ofs     = field;
      end
      KIND_STACK: begin
        seg_idx = SEG_STACK;
        ofs     = sp;
      end
      default: begin
        seg_idx = SEG_EXTRA;
        ofs     = di;
      end
    endcase
  end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
  parameter int BASE_W = 20,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic [BASE_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] sum
);

  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] ofs_ext;

  assign base_ext = ADDR_W'(base);
  assign ofs_ext  = ADDR_W'(ofs);
  assign sum      = base_ext + ofs_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_SEL_W-1:0] wr_sel,
  input  logic [ADDR_W-1:0]    wr_base,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic                 req_ovr_valid,
  input  logic [SEG_SEL_W-1:0] req_ovr_sel,
  input  logic [OFS_W-1:0]     req_ip,
  input  logic [OFS_W-1:0]     req_field,
  input  logic [OFS_W-1:0]     req_sp,
  input  logic [OFS_W-1:0]     req_di,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [ADDR_W-1:0]    out_addr
);

  logic [SEG_SEL_W-1:0] seg_idx;
  logic [OFS_W-1:0]     ofs;
  logic [ADDR_W-1:0]    base;
  logic [ADDR_W-1:0]    phys;
  logic                 accept;
  logic                 valid_q;
  logic [ADDR_W-1:0]    addr_q;

  seg_bank #(.NUM(SEG_COUNT), .SEL_W(SEG_SEL_W), .W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_base),
    .rd_sel  (seg_idx),
    .rd_base (base)
  );

  seg_select #(.OFS_W(OFS_W)) u_sel (
    .kind      (acc_kind_e'(req_kind)),
    .ovr_valid (req_ovr_valid),
    .ovr_sel   (req_ovr_sel),
    .ip        (req_ip),
    .field     (req_field),
    .sp        (req_sp),
    .di        (req_di),
    .seg_idx   (seg_idx),
    .ofs       (ofs)
  );

  seg_adder #(.BASE_W(ADDR_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_add (
    .base (base),
    .ofs  (ofs),
    .sum  (phys)
  );

  assign req_ready = !valid_q || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      addr_q  <= phys;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_addr  = addr_q;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [ADDR_W-1:0] wr_base,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [OFS_W-1:0]  req_ip,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);

  logic [ADDR_W-1:0] code_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_sh <= '0;
    else if (wr_en && wr_sel == 3'd0) code_sh <= wr_base;
  end

  // R1: output empty while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!out_valid);
    end
  end

  // R10: stalled output is frozen
  p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));

  // R10: no acceptance while stalled
  p_stall_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready);

  // R9: accepted request appears next cycle
  p_accept_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid);

  // R9: consumed output without new request empties
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && out_ready |=> !out_valid);

  // R3: fetch address is code base plus instruction pointer
  p_fetch_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_kind == 2'd0 |=>
      out_addr == ADDR_W'($past(code_sh) + ADDR_W'($past(req_ip))));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_base   (wr_base),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_ip    (req_ip),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [19:0] wr_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic        req_ovr_valid = 1'b0;
  logic [2:0]  req_ovr_sel = '0;
  logic [15:0] req_ip = '0, req_field = '0, req_sp = '0, req_di = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  int m_base [6];
  bit m_valid = 0;
  int m_addr = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_addr();
    int seg;
    int ofs;
    case (req_kind)
      2'd0: begin seg = 0; ofs = int'(req_ip); end
      2'd1: begin
        seg = (req_ovr_valid && req_ovr_sel < 3'd6) ? int'(req_ovr_sel) : 1;
        ofs = int'(req_field);
      end
      2'd2: begin seg = 2; ofs = int'(req_sp); end
      default: begin seg = 3; ofs = int'(req_di); end
    endcase
    return (m_base[seg] + ofs) & 32'hFFFFF;
  endfunction

  // one clock: inputs already set, check ready, advance, compare outputs
  task automatic step(input string tag);
    bit exp_ready;
    bit acc;
    int ea;
    #1;
    exp_ready = !m_valid || out_ready;
    chk(tag, "req_ready", int'(req_ready), int'(exp_ready));
    acc = req_valid && exp_ready;
    ea = ref_addr();
    @(posedge clk);
    if (acc) begin m_valid = 1; m_addr = ea; end
    else if (out_ready) m_valid = 0;
    if (wr_en && wr_sel < 3'd6) m_base[wr_sel] = int'(wr_base);
    #1;
    chk(tag, "out_valid", int'(out_valid), int'(m_valid));
    if (m_valid) chk(tag, "out_addr", int'(out_addr), m_addr);
  endtask

  task automatic idle();
    wr_en = 0; req_valid = 0; req_ovr_valid = 0; out_ready = 1;
  endtask

  task automatic write_seg(input int sel, input int val, input string tag);
    idle();
    wr_en = 1; wr_sel = 3'(sel); wr_base = 20'(val);
    step(tag);
    wr_en = 0;
  endtask

  task automatic request(input int kind, input bit ov, input int osel, input string tag);
    idle();
    req_valid = 1; req_kind = 2'(kind); req_ovr_valid = ov; req_ovr_sel = 3'(osel);
    req_ip = 16'h0101; req_field = 16'h0202; req_sp = 16'h0303; req_di = 16'h0404;
    step(tag);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) m_base[i] = 0;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "req_ready after reset", int'(req_ready), 1);

    // R1: zero bases, fetch returns the instruction pointer
    idle(); req_valid = 1; req_kind = 2'd0; req_ip = 16'h1234;
    step("R1");
    chk("R1", "fetch with zero base", int'(out_addr), 32'h01234);
    idle(); step("R9");

    // R2: load six distinct bases, then try the unused indices 6 and 7
    for (int s = 0; s < 6; s++) write_seg(s, 32'h10000 * (s + 1) + 32'h10 * s, "R2");
    write_seg(6, 32'hAAAAA, "R2");
    write_seg(7, 32'h55555, "R2");
    for (int s = 0; s < 6; s++) begin
      request(1, 1, s, "R2");
      chk("R2", "base survives writes to 6/7", int'(out_addr),
          (32'h10000 * (s + 1) + 32'h10 * s + 32'h0202) & 32'hFFFFF);
    end

    // R2: same-cycle write and data request uses the old base
    idle(); wr_en = 1; wr_sel = 3'd1; wr_base = 20'h038E0;
    req_valid = 1; req_kind = 2'd1; req_field = 16'h0032;
    step("R2");
    chk("R2", "old base in write cycle", int'(out_addr), 32'h20010 + 32'h0032);

    // R4: documented example
    idle(); req_valid = 1; req_kind = 2'd1; req_field = 16'h0032;
    step("R4");
    chk("R4", "038E0+0032", int'(out_addr), 32'h03912);

    // R3 R6 R7: each kind with distinct offsets, override ignored
    request(0, 0, 0, "R3");
    request(0, 1, 4, "R3");
    chk("R3", "fetch ignores override", int'(out_addr), 32'h10000 + 32'h0101);
    request(2, 0, 0, "R6");
    request(2, 1, 5, "R6");
    chk("R6", "stack ignores override", int'(out_addr), 32'h30020 + 32'h0303);
    request(3, 0, 0, "R7");
    request(3, 1, 0, "R7");
    chk("R7", "strdst ignores override", int'(out_addr), 32'h40030 + 32'h0404);

    // R5: all override codes on data; 6 and 7 fall back to data segment
    for (int s = 0; s < 8; s++) request(1, 1, s, "R5");
    chk("R5", "override 7 falls back", int'(out_addr), 32'h038E0 + 32'h0202);
    request(1, 0, 4, "R5");
    chk("R5", "override invalid ignored", int'(out_addr), 32'h038E0 + 32'h0202);

    // R8: wrap past bit 19
    write_seg(2, 32'hFFFF0, "R8");
    idle(); req_valid = 1; req_kind = 2'd2; req_sp = 16'hFFFF;
    step("R8");
    chk("R8", "carry dropped", int'(out_addr), 32'h0FFEF);

    // R10: stall with pending output and a waiting request
    idle(); out_ready = 0; req_valid = 1; req_kind = 2'd0; req_ip = 16'h0777;
    step("R10");
    step("R10");
    step("R10");
    chk("R10", "addr held", int'(out_addr), 32'h0FFEF);
    out_ready = 1;
    step("R9");
    chk("R9", "stalled request delivered", int'(out_addr), 32'h10000 + 32'h0777);
    idle(); step("R9");

    // random mix of everything
    for (int n = 0; n < 600; n++) begin
      wr_en = ($urandom_range(0, 5) == 0);
      wr_sel = 3'($urandom_range(0, 7));
      wr_base = 20'($urandom);
      req_valid = $urandom_range(0, 1);
      req_kind = 2'($urandom_range(0, 3));
      req_ovr_valid = $urandom_range(0, 1);
      req_ovr_sel = 3'($urandom_range(0, 7));
      req_ip = 16'($urandom); req_field = 16'($urandom);
      req_sp = 16'($urandom); req_di = 16'($urandom);
      out_ready = ($urandom_range(0, 3) != 0);
      step("R9/R10 random");
    end
    idle(); step("R9");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule